// File: doc/BRIEF.md
# Twin Timer/Counter

This block provides two timers. Each timer is built from two bytes: a low byte and a high byte. One 8-bit mode register configures both timers, with one nibble per timer. A control nibble holds a run bit and an overflow flag for each timer. Each timer advances on a one-cycle oscillator tick enable or on falling edges of its own external count pin. A gate pin can make counting depend on its level. Both pins are synchronized inside the block.

Four counting modes are available:
- a 13-bit prescaled counter
- a plain 16-bit counter
- an 8-bit counter that reloads itself from the high byte
- a split mode for timer 0 only

In split mode, timer 0 acts as two independent 8-bit timers. Its high byte takes over timer 1's run bit and overflow flag. Timer 1 then runs freely as a rate source. It reports every overflow through a one-cycle strobe that a baud divider can use.

Top module: `twin_tc`

## Requirements
- R1: After reset, both counts, the mode register and the control nibble are zero, and `t1_ovf_strobe` is low.
- R2: A timer's low-side count enable is run AND (NOT gate OR synchronized gate pin) AND source event. With the run bit clear, or with gate set and the gate pin low, the count holds.
- R3: With the select bit at 0, the source event is `osc_tick`. With the select bit at 1, it is a 1-to-0 transition of the two-stage synchronized count pin; `osc_tick` is then ignored.
- R4: Mode 01 is a 16-bit count {high,low}. Stepping from FFFF gives 0000 and sets the timer's flag.
- R5: Mode 00 steps only low[4:0] and leaves low[7:5] unchanged. A step from low[4:0]=1F increments the high byte. The flag sets when the high byte is FF at that moment.
- R6: In mode 10, the low byte steps. A step from FF loads the low byte with the high byte and sets the flag. The high byte is unchanged.
- R7: When timer 0 is in mode 11, its low byte is an 8-bit timer under timer 0's run, gate and select bits and sets the timer 0 flag. Its high byte steps on `osc_tick` while the timer 1 run bit is set, and on wrap it sets the timer 1 flag.
- R8: While timer 0 is in mode 11, timer 1 counts in its own mode regardless of its run bit (gate and select still apply) and never sets its flag. When timer 1 itself is in mode 11, it holds its count.
- R9: `t1_ovf_strobe` is high for the one cycle after each timer 1 overflow, whether or not the flag is updated.
- R10: The control nibble is [3] timer 1 flag, [2] timer 1 run, [1] timer 0 flag, [0] timer 0 run. Mode bits [3:0] configure timer 0 and bits [7:4] configure timer 1. Within a nibble the layout is [1:0] mode, [2] select, [3] gate. Software writes all four control bits, flags included.
- R11: An overflow in the same cycle as a control write leaves the flag set. A byte write to a timer cancels that timer's step in that cycle, and the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick enable, one cycle per tick |
| cnt_pin | input | 2 | External count pins, index = timer |
| gate_pin | input | 2 | External gate pins, index = timer |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| ctl_we | input | 1 | Control nibble write strobe |
| ctl_wdata | input | 4 | Control nibble write data |
| cnt_we | input | 4 | Byte write strobes: t0 low, t0 high, t1 low, t1 high |
| cnt_wdata | input | 8 | Byte write data |
| mode_q | output | 8 | Mode register |
| ctl_q | output | 4 | Control nibble |
| t0_count | output | 16 | Timer 0 {high, low} |
| t1_count | output | 16 | Timer 1 {high, low} |
| t1_ovf_strobe | output | 1 | One-cycle timer 1 overflow pulse |

## Verification
The functions that can coincide are a hardware overflow and a software access to the same state. One case is a control write that clears the flag in the very cycle the count wraps. Another is a byte write landing on the cycle an oscillator tick would step the timer. The bench drives both in the same cycle, from a count of FFFF and at the rollover edge. It expects the flag to read set and the written byte to be stored, with no step applied.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    TM_PRESCALE = 2'b00,
    TM_WIDE     = 2'b01,
    TM_RELOAD   = 2'b10,
    TM_SPLIT    = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate;
    logic     cnt_sel;
    tc_mode_e mode;
  } tc_nib_t;

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tc_mode_e        mode,
  input  logic            en_lo,
  input  logic            en_hi,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] count,
  output logic            ovf_main,
  output logic            ovf_split
);
  logic [BW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic lo_max, hi_max, pre_max, step_ok;

  assign lo_max  = (lo_q == '1);
  assign hi_max  = (hi_q == '1);
  assign pre_max = (lo_q[PW-1:0] == '1);
  assign step_ok = !(wr_lo || wr_hi);

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
    if (step_ok) begin
      unique case (mode)
        TM_PRESCALE: if (en_lo) begin
          lo_d[PW-1:0] = lo_q[PW-1:0] + 1'b1;
          if (pre_max) begin
            hi_d     = hi_q + 1'b1;
            ovf_main = hi_max;
          end
        end
        TM_WIDE: if (en_lo) begin
          lo_d = lo_q + 1'b1;
          if (lo_max) begin
            hi_d     = hi_q + 1'b1;
            ovf_main = hi_max;
          end
        end
        TM_RELOAD: if (en_lo) begin
          if (lo_max) begin
            lo_d     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        TM_SPLIT: begin
          if (en_lo) begin
            lo_d     = lo_q + 1'b1;
            ovf_main = lo_max;
          end
          if (en_hi) begin
            hi_d      = hi_q + 1'b1;
            ovf_split = hi_max;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/twin_tc.sv
module twin_tc
  import tc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic              mode_we,
  input  logic [7:0]        mode_wdata,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic [3:0]        cnt_we,
  input  logic [BYTE_W-1:0] cnt_wdata,
  output logic [7:0]        mode_q,
  output logic [3:0]        ctl_q,
  output logic [2*BYTE_W-1:0] t0_count,
  output logic [2*BYTE_W-1:0] t1_count,
  output logic              t1_ovf_strobe
);
  localparam int NT  = 2;
  localparam int CW  = 2 * BYTE_W;
  localparam int B_TR0 = 0, B_TF0 = 1, B_TR1 = 2, B_TF1 = 3;

  logic [7:0]    mode_r, mode_n;
  logic [3:0]    ctl_r, ctl_n;
  logic          strobe_r, strobe_n;
  logic [NT-1:0] pin_lvl, pin_prev, pin_fall, gate_lvl;
  logic [NT-1:0] src, gate_ok, run, en_lo, en_hi;
  logic [NT-1:0] ovf_main_w, ovf_split_w;
  logic [CW-1:0] cnt_w [NT];
  tc_nib_t       nib [NT];
  logic          split0, set_tf1;

  assign split0 = (nib[0].mode == TM_SPLIT);
  assign run[0] = ctl_r[B_TR0];
  assign run[1] = split0 ? 1'b1 : ctl_r[B_TR1];
  assign en_hi[0] = split0 & ctl_r[B_TR1] & osc_tick;
  assign en_hi[1] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_tmr
      assign nib[gi] = tc_nib_t'(mode_r[4*gi +: 4]);

      tc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnt_pin[gi]), .level_o(pin_lvl[gi]));
      tc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_in(gate_pin[gi]), .level_o(gate_lvl[gi]));

      assign pin_fall[gi] = pin_prev[gi] & ~pin_lvl[gi];
      assign src[gi]      = nib[gi].cnt_sel ? pin_fall[gi] : osc_tick;
      assign gate_ok[gi]  = ~nib[gi].gate | gate_lvl[gi];
      if (gi == 0) begin : g_lo0
        assign en_lo[gi] = run[gi] & gate_ok[gi] & src[gi];
      end else begin : g_lo1
        assign en_lo[gi] = run[gi] & gate_ok[gi] & src[gi] & (nib[gi].mode != TM_SPLIT);
      end

      tc_core #(.BW(BYTE_W), .PW(PRE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(nib[gi].mode),
        .en_lo(en_lo[gi]), .en_hi(en_hi[gi]),
        .wr_lo(cnt_we[2*gi]), .wr_hi(cnt_we[2*gi+1]), .wdata(cnt_wdata),
        .count(cnt_w[gi]), .ovf_main(ovf_main_w[gi]), .ovf_split(ovf_split_w[gi]));
    end
  endgenerate

  assign set_tf1 = (split0 & ovf_split_w[0]) | (~split0 & ovf_main_w[1]) | ovf_split_w[1];

  always_comb begin
    mode_n = mode_r;
    if (mode_we) mode_n = mode_wdata;
    ctl_n = ctl_r;
    if (ctl_we) ctl_n = ctl_wdata;
    if (ovf_main_w[0]) ctl_n[B_TF0] = 1'b1;
    if (set_tf1)       ctl_n[B_TF1] = 1'b1;
    strobe_n = ovf_main_w[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= '0;
      ctl_r    <= '0;
      strobe_r <= 1'b0;
      pin_prev <= '0;
    end else begin
      mode_r   <= mode_n;
      ctl_r    <= ctl_n;
      strobe_r <= strobe_n;
      pin_prev <= pin_lvl;
    end
  end

  assign mode_q        = mode_r;
  assign ctl_q         = ctl_r;
  assign t0_count      = cnt_w[0];
  assign t1_count      = cnt_w[1];
  assign t1_ovf_strobe = strobe_r;
endmodule

// File: rtl/twin_tc_chk.sv
module twin_tc_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    t0_md,
  input logic [1:0]    t1_md,
  input logic          tr0,
  input logic          tf0,
  input logic          tf1,
  input logic          sw_tf0,
  input logic          sw_tf1,
  input logic [3:0]    cnt_we,
  input logic [2*BW-1:0] t0_count,
  input logic [2*BW-1:0] t1_count,
  input logic          strobe,
  input logic [1:0]    ovf_main,
  input logic          ovf_split0
);
  // R4: a timer 0 flag only rises from an overflow or a software write
  p_tf0_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf0) |-> $past(ovf_main[0] | sw_tf0));

  // R7: a timer 1 flag only rises from its overflow sources or software
  p_tf1_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf1) |-> $past(ovf_split0 | ovf_main[1] | sw_tf1));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_main[0] |=> tf0);

  p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr0 && t0_md != 2'b11 && cnt_we[1:0] == 2'b00) |=> $stable(t0_count));

  p_t1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_md == 2'b11 && cnt_we[3:2] == 2'b00) |=> $stable(t1_count));

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_main[1] |=> strobe);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_md == 2'b10 && ovf_main[0]) |=> t0_count[BW-1:0] == $past(t0_count[2*BW-1:BW]));
endmodule

bind twin_tc twin_tc_chk #(.BW(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .t0_md(mode_q[1:0]), .t1_md(mode_q[5:4]),
  .tr0(ctl_q[0]), .tf0(ctl_q[1]), .tf1(ctl_q[3]),
  .sw_tf0(ctl_we & ctl_wdata[1]), .sw_tf1(ctl_we & ctl_wdata[3]),
  .cnt_we(cnt_we), .t0_count(t0_count), .t1_count(t1_count),
  .strobe(t1_ovf_strobe), .ovf_main(ovf_main_w), .ovf_split0(ovf_split_w[0]));

// File: tb/twin_tc_bench.sv
`timescale 1ns/1ps
module twin_tc_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic osc_tick;
  logic [1:0] cnt_pin, gate_pin;
  logic mode_we, ctl_we;
  logic [7:0] mode_wdata, cnt_wdata;
  logic [3:0] ctl_wdata, cnt_we;
  logic [7:0] mode_q;
  logic [3:0] ctl_q;
  logic [15:0] t0_count, t1_count;
  logic t1_ovf_strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twin_tc u_twin_tc (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .mode_q(mode_q), .ctl_q(ctl_q),
    .t0_count(t0_count), .t1_count(t1_count), .t1_ovf_strobe(t1_ovf_strobe));

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] lo, hi, n, elo, ehi;
    logic       etf;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{2'b01, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 1'b0},
    '{2'b01, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    '{2'b00, 8'hFE, 8'h05, 8'd3, 8'hE1, 8'h06, 1'b0},
    '{2'b00, 8'h3F, 8'hFF, 8'd1, 8'h20, 8'h00, 1'b1},
    '{2'b10, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 1'b1},
    '{2'b10, 8'h10, 8'h20, 8'd5, 8'h15, 8'h20, 1'b0},
    '{2'b11, 8'hFF, 8'h00, 8'd2, 8'h01, 8'h00, 1'b1}
  };
  localparam string VREQ [4] = '{"R5", "R4", "R6", "R7"};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(input int idx, input logic [7:0] v);
    @(negedge clk); cnt_we = '0; cnt_we[idx] = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk); cnt_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; cnt_pin = '0; gate_pin = '0;
    mode_we = 1'b0; ctl_we = 1'b0; mode_wdata = '0; ctl_wdata = '0;
    cnt_we = '0; cnt_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", t0_count, 16'h0000);
    chk("R1", t1_count, 16'h0000);
    chk("R1", {8'h0, mode_q}, 16'h0000);
    chk("R1", {12'h0, ctl_q}, 16'h0000);
    chk("R1", {15'h0, t1_ovf_strobe}, 16'h0000);

    // vector table on timer 0, oscillator source, no gate
    for (int i = 0; i < 7; i++) begin
      wr_ctl(4'b0000);
      wr_mode({6'b000000, VT[i].md});
      wr_cnt(0, VT[i].lo);
      wr_cnt(1, VT[i].hi);
      wr_ctl(4'b0001);
      ticks(int'(VT[i].n));
      chk(VREQ[VT[i].md], t0_count, {VT[i].ehi, VT[i].elo});
      chk(VREQ[VT[i].md], {15'h0, ctl_q[1]}, {15'h0, VT[i].etf});
    end

    // R7 split: high byte runs on timer 1 run bit, sets timer 1 flag (R10 layout)
    wr_ctl(4'b0000);
    wr_mode(8'h03);
    wr_cnt(0, 8'h40);
    wr_cnt(1, 8'hFF);
    wr_ctl(4'b0100);
    ticks(1);
    chk("R7", t0_count, 16'h0040);
    chk("R10", {12'h0, ctl_q}, 16'h000C);

    // R8 timer 1 free-running while timer 0 split, strobe R9
    wr_ctl(4'b0000);
    wr_mode(8'h23);
    wr_cnt(2, 8'hFF);
    wr_cnt(3, 8'hF0);
    ticks(1);
    chk("R9", {15'h0, t1_ovf_strobe}, 16'h0001);
    chk("R6", t1_count, 16'hF0F0);
    @(negedge clk);
    chk("R9", {15'h0, t1_ovf_strobe}, 16'h0000);
    chk("R8", {12'h0, ctl_q}, 16'h0000);
    ticks(2);
    chk("R8", t1_count, 16'hF0F2);
    chk("R8", t0_count, 16'h0040);

    // R8 timer 1 in mode 11 holds
    wr_mode(8'h31);
    wr_ctl(4'b0100);
    ticks(3);
    chk("R8", t1_count, 16'hF0F2);

    // R2 gating and run bit
    wr_ctl(4'b0000);
    wr_mode(8'h09);
    wr_cnt(0, 8'h00);
    wr_cnt(1, 8'h00);
    wr_ctl(4'b0001);
    ticks(4);
    chk("R2", t0_count, 16'h0000);
    gate_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    ticks(2);
    chk("R2", t0_count, 16'h0002);
    wr_ctl(4'b0000);
    ticks(2);
    chk("R2", t0_count, 16'h0002);

    // R3 counter mode: pin falling edges only
    wr_mode(8'h05);
    wr_cnt(0, 8'h00);
    wr_ctl(4'b0001);
    ticks(5);
    chk("R3", t0_count, 16'h0000);
    for (int k = 0; k < 3; k++) pin_pulse();
    chk("R3", t0_count, 16'h0003);

    // R11 overflow versus flag clear in the same cycle
    wr_ctl(4'b0000);
    wr_mode(8'h01);
    wr_cnt(0, 8'hFF);
    wr_cnt(1, 8'hFF);
    wr_ctl(4'b0001);
    @(negedge clk); osc_tick = 1'b1; ctl_we = 1'b1; ctl_wdata = 4'b0001;
    @(negedge clk); osc_tick = 1'b0; ctl_we = 1'b0;
    chk("R11", t0_count, 16'h0000);
    chk("R11", {15'h0, ctl_q[1]}, 16'h0001);
    // R11 byte write versus step in the same cycle
    @(negedge clk); osc_tick = 1'b1; cnt_we = 4'b0001; cnt_wdata = 8'h55;
    @(negedge clk); osc_tick = 1'b0; cnt_we = 4'b0000;
    chk("R11", t0_count, 16'h0055);

    // R10 software sets a flag directly
    wr_ctl(4'b1000);
    chk("R10", {12'h0, ctl_q}, 16'h0008);

    finish_run();
  end
endmodule